// File: doc/BRIEF.md
# Dual-Slot Shared Bus Writer

This block drives the single 16-bit outgoing bus that a group of compute cells shares. The two instructions of one two-wide schedule row each present a write request, a width flag and a data word. The block merges them onto the bus. Each slot owns one byte lane: slot 0 owns the low byte and slot 1 owns the high byte. Two byte writes can therefore go out together, while a 16-bit write needs the whole bus to itself.

The block also drives one valid flag per byte lane, so that a receiver knows which lanes carry data. When the two requests cannot share the bus, it raises a conflict flag, and in that case slot 0 is served. All outputs are registered and change one clock after the request is presented.

Top module: `dual_slot_bus_writer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `bus_data`, `lane_vld` and `clash` all become zero on that edge.
- R2: Outputs reflect the inputs sampled at the previous rising edge. A change of inputs between edges does not alter the outputs until the next edge.
- R3: A 16-bit write (`req`=1, `wide`=1) from a slot whose request is not overridden places that slot's full 16-bit data on `bus_data` and sets `lane_vld`=2'b11.
- R4: When both slots request 8-bit writes, `bus_data[7:0]` equals `s0_data[7:0]` and `bus_data[15:8]` equals `s1_data[7:0]`. `lane_vld` is 2'b11 and `clash` is 0.
- R5: An 8-bit write uses the low byte of the slot's data and drives only that slot's lane: lane 0 (`lane_vld[0]`) for slot 0, lane 1 (`lane_vld[1]`) for slot 1. The other lane's valid flag stays 0 unless the other slot also writes.
- R6: When both slots request and at least one request is 16-bit, slot 0 alone is served, as a 16-bit write or as an 8-bit write on lane 0, and `clash` is 1 for that cycle. Slot 1's request is dropped.
- R7: Every lane whose valid flag is 0 carries zero data. With no requests, the outputs are all zero and `clash` is 0.
- R8: A slot's `wide` and `data` inputs have no effect on the outputs while its `req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| s0_req | input | 1 | Slot 0 write request |
| s0_wide | input | 1 | Slot 0 width: 1 = 16-bit, 0 = 8-bit |
| s0_data | input | 16 | Slot 0 write data; an 8-bit write uses bits 7:0 |
| s1_req | input | 1 | Slot 1 write request |
| s1_wide | input | 1 | Slot 1 width: 1 = 16-bit, 0 = 8-bit |
| s1_data | input | 16 | Slot 1 write data; an 8-bit write uses bits 7:0 |
| bus_data | output | 16 | Registered bus word |
| lane_vld | output | 2 | Per-byte valid; bit 0 = low byte, bit 1 = high byte |
| clash | output | 1 | Requests could not share the bus this cycle |

## Verification
On every cycle after reset, the assertions check:
- that slot 0 takes over the bus after any 16-bit request of its own;
- that two byte writes are merged without a conflict;
- that a conflict only follows two requests of which one is wide;
- that idle lanes carry zero.

Some behaviours only the bench's scenarios can show. These are the exact lane placement of slot 1's data, the dropping of slot 1 under a conflict, the one-cycle latency, and the insensitivity to the `wide` and `data` inputs of a slot that is not requesting. The bench shows these by sweeping every request and width combination against several data patterns.

// File: rtl/bus_writer_pkg.sv
package bus_writer_pkg;

  typedef struct packed {
    logic        req;
    logic        wide;
    logic [15:0] data;
  } slot_req_t;

endpackage

// File: rtl/bus_writer_arb.sv
module bus_writer_arb #(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic             s0_req,
  input  logic             s0_wide,
  input  logic [BUS_W-1:0] s0_data,
  input  logic             s1_req,
  input  logic             s1_wide,
  input  logic [BUS_W-1:0] s1_data,
  output logic [BUS_W-1:0] nxt_data,
  output logic [1:0]       nxt_vld,
  output logic             nxt_clash
);

  logic s0_full;
  logic s1_full;

  assign s0_full = s0_req && s0_wide;
  assign s1_full = s1_req && s1_wide;

  // The requests collide when both slots ask for the bus and either one
  // wants all of it.
  assign nxt_clash = s0_req && s1_req && (s0_wide || s1_wide);

  always_comb begin
    nxt_data = '0;
    nxt_vld  = 2'b00;
    if (s0_full) begin
      nxt_data = s0_data;
      nxt_vld  = 2'b11;
    end else if (s0_req) begin
      nxt_data[LANE_W-1:0] = s0_data[LANE_W-1:0];
      nxt_vld[0]           = 1'b1;
      if (s1_req && !s1_wide) begin
        nxt_data[BUS_W-1:LANE_W] = s1_data[LANE_W-1:0];
        nxt_vld[1]               = 1'b1;
      end
    end else if (s1_full) begin
      nxt_data = s1_data;
      nxt_vld  = 2'b11;
    end else if (s1_req) begin
      nxt_data[BUS_W-1:LANE_W] = s1_data[LANE_W-1:0];
      nxt_vld[1]               = 1'b1;
    end
  end

  // r5_: a lane-1 grant during a slot-0 byte write needs a slot-1 byte request
  always_comb begin
    if (s0_req && !s0_wide && nxt_vld[1]) begin
      a_r5_lane1_owner: assert (s1_req && !s1_wide);
    end
  end

endmodule

// File: rtl/bus_writer_lane_reg.sv
module bus_writer_lane_reg #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] d_data,
  input  logic [LANES-1:0] d_vld,
  output logic [BUS_W-1:0] q_data,
  output logic [LANES-1:0] q_vld
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        q_data[g*LANE_W +: LANE_W] <= '0;
        q_vld[g]                   <= 1'b0;
      end else begin
        q_data[g*LANE_W +: LANE_W] <= d_vld[g] ? d_data[g*LANE_W +: LANE_W] : '0;
        q_vld[g]                   <= d_vld[g];
      end
    end

    a_r7_idle_lane_zero: assert property (@(posedge clk) disable iff (rst)
      !q_vld[g] |-> (q_data[g*LANE_W +: LANE_W] == '0));
  end

endmodule

// File: rtl/dual_slot_bus_writer.sv
module dual_slot_bus_writer #(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s0_req,
  input  logic             s0_wide,
  input  logic [BUS_W-1:0] s0_data,
  input  logic             s1_req,
  input  logic             s1_wide,
  input  logic [BUS_W-1:0] s1_data,
  output logic [BUS_W-1:0] bus_data,
  output logic [1:0]       lane_vld,
  output logic             clash
);

  logic [BUS_W-1:0] nxt_data;
  logic [1:0]       nxt_vld;
  logic             nxt_clash;
  logic             chk_armed;

  bus_writer_arb #(.LANE_W(LANE_W)) arb_i (
    .s0_req    (s0_req),
    .s0_wide   (s0_wide),
    .s0_data   (s0_data),
    .s1_req    (s1_req),
    .s1_wide   (s1_wide),
    .s1_data   (s1_data),
    .nxt_data  (nxt_data),
    .nxt_vld   (nxt_vld),
    .nxt_clash (nxt_clash)
  );

  bus_writer_lane_reg #(.LANE_W(LANE_W), .LANES(2)) lanes_i (
    .clk    (clk),
    .rst    (rst),
    .d_data (nxt_data),
    .d_vld  (nxt_vld),
    .q_data (bus_data),
    .q_vld  (lane_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clash     <= 1'b0;
      chk_armed <= 1'b0;
    end else begin
      clash     <= nxt_clash;
      chk_armed <= 1'b1;
    end
  end

  a_r3_slot0_wide_owns: assert property (@(posedge clk) disable iff (rst)
    chk_armed && $past(s0_req && s0_wide)
      |-> (lane_vld == 2'b11) && (bus_data == $past(s0_data)));

  a_r4_bytes_merge: assert property (@(posedge clk) disable iff (rst)
    chk_armed && $past(s0_req && !s0_wide && s1_req && !s1_wide)
      |-> (lane_vld == 2'b11) && !clash);

  a_r6_clash_cause: assert property (@(posedge clk) disable iff (rst)
    chk_armed && clash |-> $past(s0_req && s1_req && (s0_wide || s1_wide)));

  a_r6_slot0_lane: assert property (@(posedge clk) disable iff (rst)
    chk_armed && clash |-> lane_vld[0]);

endmodule

// File: tb/dual_slot_bus_writer_tb_top.sv
module dual_slot_bus_writer_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        s0_req, s0_wide, s1_req, s1_wide;
  logic [15:0] s0_data, s1_data;
  logic [15:0] bus_data;
  logic [1:0]  lane_vld;
  logic        clash;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_slot_bus_writer #(.LANE_W(8)) dut_i (
    .clk(clk), .rst(rst),
    .s0_req(s0_req), .s0_wide(s0_wide), .s0_data(s0_data),
    .s1_req(s1_req), .s1_wide(s1_wide), .s1_data(s1_data),
    .bus_data(bus_data), .lane_vld(lane_vld), .clash(clash)
  );

  task automatic check(input string tag, input logic [15:0] ed,
                       input logic [1:0] ev, input logic ec);
    checks++;
    if (bus_data !== ed || lane_vld !== ev || clash !== ec) begin
      errors++;
      $display("FAIL %s: got data=%h vld=%b clash=%b expected data=%h vld=%b clash=%b",
               tag, bus_data, lane_vld, clash, ed, ev, ec);
    end
  endtask

  task automatic drive(input logic r0, input logic w0, input logic [15:0] d0,
                       input logic r1, input logic w1, input logic [15:0] d1);
    s0_req = r0; s0_wide = w0; s0_data = d0;
    s1_req = r1; s1_wide = w1; s1_data = d1;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] ed;
    logic [1:0]  ev;
    logic        ec;
    string       tag;

    rst = 1'b1;
    drive(0, 0, 16'h0, 0, 0, 16'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 16'h0, 2'b00, 1'b0);
    rst = 1'b0;

    // R2: outputs hold until the next edge after an input change
    drive(1, 1, 16'hBEEF, 0, 0, 16'h0);
    #1;
    check("R2 no change before edge", 16'h0, 2'b00, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2 update after one edge", 16'hBEEF, 2'b11, 1'b0);

    // Exhaustive sweep over request and width combinations.
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic r0, w0, r1, w1;
        logic [15:0] d0, d1;
        r0 = c[0]; w0 = c[1]; r1 = c[2]; w1 = c[3];
        d0 = 16'hA5C3 ^ (16'(p) * 16'h1357);
        d1 = 16'h3C96 + (16'(p) * 16'h2468);
        drive(r0, w0, d0, r1, w1, d1);
        ed = 16'h0; ev = 2'b00; ec = 1'b0;
        ec = r0 && r1 && (w0 || w1);
        if (r0 && w0) begin
          ed = d0; ev = 2'b11; tag = ec ? "R6 wide clash slot0 wins" : "R3 slot0 wide";
        end else if (r0) begin
          ed[7:0] = d0[7:0]; ev[0] = 1'b1;
          if (r1 && !w1) begin
            ed[15:8] = d1[7:0]; ev[1] = 1'b1; tag = "R4 both bytes";
          end else begin
            tag = ec ? "R6 slot1 wide dropped" : "R5 slot0 byte";
          end
        end else if (r1 && w1) begin
          ed = d1; ev = 2'b11; tag = "R3 slot1 wide";
        end else if (r1) begin
          ed[15:8] = d1[7:0]; ev[1] = 1'b1; tag = "R5 slot1 byte";
        end else begin
          tag = "R7 idle";
        end
        @(posedge clk); @(negedge clk);
        check(tag, ed, ev, ec);
      end
    end

    // R8: wide/data of non-requesting slots ignored
    drive(0, 1, 16'hFFFF, 1, 0, 16'h12AB);
    @(posedge clk); @(negedge clk);
    check("R8 idle slot0 ignored", 16'hAB00, 2'b10, 1'b0);
    drive(1, 0, 16'h5A77, 0, 1, 16'hFFFF);
    @(posedge clk); @(negedge clk);
    check("R8 idle slot1 ignored", 16'h0077, 2'b01, 1'b0);
    drive(0, 1, 16'hDEAD, 0, 1, 16'hF00D);
    @(posedge clk); @(negedge clk);
    check("R8 R7 both idle", 16'h0000, 2'b00, 1'b0);

    // R1: reset mid-run overrides active requests
    drive(1, 1, 16'h7777, 1, 0, 16'h8888);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 reset with requests", 16'h0, 2'b00, 1'b0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 after reset release", 16'h7777, 2'b11, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule